// File: doc/BRIEF.md
# Jitter-Counting Random Bit Harvester

The harvester converts the jittery timing of an off-chip analog event into random bits. It drives a repeating excitation pulse (`pulse_out`) whose high and low phases last a programmable number of fast-clock cycles. During the high phase an off-chip comparator pulls the active-low enable `en_n` low after a variable delay. While the enable is low, a counter on the fast clock advances. The counter restarts at the start of every window and holds its value once the pulse falls. The parity of the held count is the raw random bit for that window.

Raw bits pass through a Von Neumann debiasing stage that consumes them in non-overlapping pairs. The stage emits a bit only when the two members of a pair differ, so a constant bias in the raw stream is removed. A health monitor raises a flag when the raw bit has not changed over a long run of windows, which shows that the enable is stuck or the device has stopped switching.

Top module: `jitter_bit_harvester`

## Requirements
- R1: While and right after the synchronous reset `rst`: `pulse_out` is 1, `raw_valid`, `out_valid` and `stuck_flag` are 0, and the debiaser holds no pending pair member.
- R2: `pulse_out` stays high for `cfg_high` cycles and then low for `cfg_low` cycles, and this repeats. Call the cycles of the high phase 0 to H-1.
- R3: `en_n` passes through a two-stage synchronizer. High-phase cycle j (1 ≤ j ≤ H-1) adds one to the count exactly when `en_n` was low at the clock edge that closes cycle j-2.
- R4: A high `en_n`, seen through the synchronizer, freezes the count. The count is also held for the whole low phase.
- R5: The count is cleared in cycle 0 of every window, so no count carries over from one window to the next.
- R6: `raw_valid` pulses for exactly one cycle, in low-phase cycle H+1, with `raw_bit` equal to bit 0 of the held count.
- R7: Raw bits are paired in arrival order. For the pair (first, second), 0 then 1 emits 0 and 1 then 0 emits 1 (the emitted bit equals the first member). Pairs 00 and 11 emit nothing. The emitted bit appears in the cycle after the second member's `raw_valid`.
- R8: `out_valid` is high for exactly one cycle per emitted bit.
- R9: `stuck_flag` updates in the cycle after each `raw_valid`. It is 1 when the latest 64 raw bits are all equal, and it returns to 0 after the first raw bit that differs.
- R10: A reset between the two members of a pair discards the pending member. The first raw bit after reset starts a new pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_high | input | DUR_W | High-phase length in cycles (values below 2 act as 2) |
| cfg_low | input | DUR_W | Low-phase length in cycles (values below 4 act as 4) |
| en_n | input | 1 | Asynchronous active-low count enable from the comparator |
| pulse_out | output | 1 | Excitation pulse train, one period per bit window |
| raw_bit | output | 1 | Parity of the held count |
| raw_valid | output | 1 | One-cycle strobe for `raw_bit` |
| out_bit | output | 1 | Debiased random bit |
| out_valid | output | 1 | One-cycle strobe for `out_bit` |
| stuck_flag | output | 1 | Raw bit constant over the last 64 windows |

## Verification
The hardest state to reach from the ports is the stuck condition. It needs 64 consecutive windows with an identical raw bit, and the check must show that the flag is still low at the 63rd window and rises exactly at the 64th. The bench gets there by resetting and then holding the enable inactive for a long series of windows. It then breaks the run with one odd-count window. A reset placed while a pair member is pending is forced by first steering the raw stream into a lone 1. Cycle-exact enable placement at every offset across the high phase pins down the two-flop latency and the clearing of the count at each window start.

// File: rtl/jbh_pkg.sv
package jbh_pkg;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

endpackage

// File: rtl/jbh_window_gen.sv
module jbh_window_gen
   import jbh_pkg::*;
#(
   parameter int DUR_W    = 8,
   parameter int MIN_HIGH = 2,
   parameter int MIN_LOW  = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DUR_W-1:0] cfg_high,
   input  logic [DUR_W-1:0] cfg_low,
   output logic             pulse_o,
   output logic             start_o,
   output logic             end_o
);

   localparam logic [DUR_W-1:0] HMIN = DUR_W'(MIN_HIGH);
   localparam logic [DUR_W-1:0] LMIN = DUR_W'(MIN_LOW);

   initial begin
      assert (MIN_HIGH >= 2 && MIN_LOW >= 4 && DUR_W >= 3)
         else $error("jbh_window_gen: minimum phase lengths too small");
   end

   phase_e           phase_q;
   logic [DUR_W-1:0] tick_q;
   logic [DUR_W-1:0] eff_high;
   logic [DUR_W-1:0] eff_low;
   logic [DUR_W-1:0] limit;
   logic             at_last;

   always_comb begin
      eff_high = (cfg_high < HMIN) ? HMIN : cfg_high;
      eff_low  = (cfg_low  < LMIN) ? LMIN : cfg_low;
      limit    = (phase_q == PH_HIGH) ? eff_high : eff_low;
      at_last  = (tick_q == limit - 1'b1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_HIGH;
         tick_q  <= '0;
      end else if (at_last) begin
         phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
         tick_q  <= '0;
      end else begin
         tick_q  <= tick_q + 1'b1;
      end
   end

   assign pulse_o = (phase_q == PH_HIGH);
   assign start_o = pulse_o && (tick_q == '0);
   assign end_o   = !pulse_o && (tick_q == '0);

endmodule

// File: rtl/jbh_gated_counter.sv
module jbh_gated_counter #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic en_n_async,
   input  logic win_high_i,
   input  logic start_i,
   input  logic end_i,
   output logic raw_bit_o,
   output logic raw_valid_o
);

   initial begin
      assert (SYNC_STAGES >= 2 && CNT_W >= 1)
         else $error("jbh_gated_counter: need at least two sync stages");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   en_sync_n;
   logic [CNT_W-1:0]       count_q;

   // Enable synchronizer; reset value is the inactive level.
   always_ff @(posedge clk) begin
      if (rst) sync_q <= '1;
      else     sync_q <= {sync_q[SYNC_STAGES-2:0], en_n_async};
   end

   assign en_sync_n = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (rst)                          count_q <= '0;
      else if (start_i)                 count_q <= '0;
      else if (win_high_i && !en_sync_n) count_q <= count_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         raw_valid_o <= 1'b0;
         raw_bit_o   <= 1'b0;
      end else begin
         raw_valid_o <= end_i;
         if (end_i) raw_bit_o <= count_q[0];
      end
   end

   // R4: count holds through the low phase
   assert_hold_low_phase_R4: assert property (@(posedge clk) disable iff (rst)
      !win_high_i |=> $stable(count_q));

   // R4: inactive synchronized enable freezes the count
   assert_freeze_disabled_R4: assert property (@(posedge clk) disable iff (rst)
      (en_sync_n && !start_i) |=> $stable(count_q));

endmodule

// File: rtl/jbh_vn_debias.sv
module jbh_vn_debias (
   input  logic clk,
   input  logic rst,
   input  logic raw_bit_i,
   input  logic raw_valid_i,
   output logic out_bit_o,
   output logic out_valid_o
);

   logic have_first_q;
   logic first_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         have_first_q <= 1'b0;
         first_q      <= 1'b0;
         out_valid_o  <= 1'b0;
         out_bit_o    <= 1'b0;
      end else if (raw_valid_i) begin
         if (!have_first_q) begin
            have_first_q <= 1'b1;
            first_q      <= raw_bit_i;
            out_valid_o  <= 1'b0;
         end else begin
            have_first_q <= 1'b0;
            out_valid_o  <= (first_q != raw_bit_i);
            out_bit_o    <= first_q;
         end
      end else begin
         out_valid_o <= 1'b0;
      end
   end

   assert_one_cycle_strobe_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid_o |=> !out_valid_o);

   assert_emit_follows_raw_R7: assert property (@(posedge clk) disable iff (rst)
      out_valid_o |-> $past(raw_valid_i));

endmodule

// File: rtl/jbh_stuck_monitor.sv
module jbh_stuck_monitor #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst,
   input  logic raw_bit_i,
   input  logic raw_valid_i,
   output logic stuck_o
);

   localparam int RUN_W = $clog2(LIMIT + 1);
   localparam logic [RUN_W-1:0] LIM = RUN_W'(LIMIT);

   initial begin
      assert (LIMIT >= 2) else $error("jbh_stuck_monitor: LIMIT below 2");
   end

   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_nxt;
   logic             last_q;

   always_comb begin
      if (run_q != '0 && raw_bit_i == last_q)
         run_nxt = (run_q == LIM) ? run_q : run_q + 1'b1;
      else
         run_nxt = RUN_W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q   <= '0;
         last_q  <= 1'b0;
         stuck_o <= 1'b0;
      end else if (raw_valid_i) begin
         run_q   <= run_nxt;
         last_q  <= raw_bit_i;
         stuck_o <= (run_nxt >= LIM);
      end
   end

   assert_flag_on_raw_R9: assert property (@(posedge clk) disable iff (rst)
      $rose(stuck_o) |-> $past(raw_valid_i));

endmodule

// File: rtl/jitter_bit_harvester.sv
module jitter_bit_harvester #(
   parameter int DUR_W       = 8,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int STUCK_LIMIT = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DUR_W-1:0] cfg_high,
   input  logic [DUR_W-1:0] cfg_low,
   input  logic             en_n,
   output logic             pulse_out,
   output logic             raw_bit,
   output logic             raw_valid,
   output logic             out_bit,
   output logic             out_valid,
   output logic             stuck_flag
);

   logic win_start;
   logic win_end;

   jbh_window_gen #(
      .DUR_W    (DUR_W),
      .MIN_HIGH (2),
      .MIN_LOW  (4)
   ) u_win (
      .clk      (clk),
      .rst      (rst),
      .cfg_high (cfg_high),
      .cfg_low  (cfg_low),
      .pulse_o  (pulse_out),
      .start_o  (win_start),
      .end_o    (win_end)
   );

   jbh_gated_counter #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_cnt (
      .clk         (clk),
      .rst         (rst),
      .en_n_async  (en_n),
      .win_high_i  (pulse_out),
      .start_i     (win_start),
      .end_i       (win_end),
      .raw_bit_o   (raw_bit),
      .raw_valid_o (raw_valid)
   );

   jbh_vn_debias u_vn (
      .clk         (clk),
      .rst         (rst),
      .raw_bit_i   (raw_bit),
      .raw_valid_i (raw_valid),
      .out_bit_o   (out_bit),
      .out_valid_o (out_valid)
   );

   jbh_stuck_monitor #(
      .LIMIT (STUCK_LIMIT)
   ) u_mon (
      .clk         (clk),
      .rst         (rst),
      .raw_bit_i   (raw_bit),
      .raw_valid_i (raw_valid),
      .stuck_o     (stuck_flag)
   );

   // R6: raw strobe only inside the low phase
   assert_raw_in_low_phase_R6: assert property (@(posedge clk) disable iff (rst)
      raw_valid |-> !pulse_out);

   // R8: the two strobes never coincide
   assert_strobes_apart_R8: assert property (@(posedge clk) disable iff (rst)
      !(raw_valid && out_valid));

endmodule

// File: tb/jitter_bit_harvester_tb.sv
`timescale 1ns/1ps
module jitter_bit_harvester_tb;

   localparam int H = 16;
   localparam int L = 6;
   localparam int LIMIT = 64;

   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] cfg_high = 8'(H);
   logic [7:0] cfg_low  = 8'(L);
   logic       en_n;
   logic       pulse_out, raw_bit, raw_valid, out_bit, out_valid, stuck_flag;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   bit have_first;
   bit first_bit;
   int run_len;
   bit last_raw;
   bit prelow;

   always #2.5 clk = ~clk;

   jitter_bit_harvester u_dut (
      .clk        (clk),
      .rst        (rst),
      .cfg_high   (cfg_high),
      .cfg_low    (cfg_low),
      .en_n       (en_n),
      .pulse_out  (pulse_out),
      .raw_bit    (raw_bit),
      .raw_valid  (raw_valid),
      .out_bit    (out_bit),
      .out_valid  (out_valid),
      .stuck_flag (stuck_flag)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_cnt(input int a, input int b, input bit pl);
      int s, e;
      s = pl ? 1 : ((a + 2 > 1) ? a + 2 : 1);
      e = (b + 1 < H - 1) ? b + 1 : H - 1;
      return (e >= s) ? e - s + 1 : 0;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst  = 1'b1;
      en_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 pulse_out in reset", int'(pulse_out), 1);
      chk("R1 raw_valid in reset", int'(raw_valid), 0);
      chk("R1 out_valid in reset", int'(out_valid), 0);
      chk("R1 stuck_flag in reset", int'(stuck_flag), 0);
      rst = 1'b0;
      have_first = 0;
      first_bit  = 0;
      run_len    = 0;
      last_raw   = 0;
      prelow     = 0;
   endtask

   // Entered at the negedge of high-phase cycle 0 (or anywhere in the high
   // phase when chklen is 0). Returns at the negedge of the next cycle 0.
   task automatic run_win(input int a, input int b, input bit nl,
                          input bit chklen, input string tag);
      int j;
      int k;
      bit expr;
      bit ev;
      expr = bit'(exp_cnt(a, b, prelow) & 1);
      j = 0;
      while (pulse_out == 1'b1) begin
         if (j == a) en_n = 1'b0;
         if (j == b) en_n = 1'b1;
         @(negedge clk);
         j++;
      end
      if (chklen) chk("R2 high length", j, H);
      en_n   = nl ? 1'b0 : 1'b1;
      prelow = nl;
      @(negedge clk);
      chk({tag, " raw_valid at H+1"}, int'(raw_valid), 1);
      chk({tag, " raw_bit parity"}, int'(raw_bit), int'(expr));
      @(negedge clk);
      chk("R6 raw_valid single cycle", int'(raw_valid), 0);
      if (have_first) begin
         ev = (first_bit != expr);
         chk("R7 out_valid on pair", int'(out_valid), int'(ev));
         if (ev) chk("R7 out_bit equals first member", int'(out_bit), int'(first_bit));
         have_first = 0;
      end else begin
         chk("R7 R10 no emit on first member", int'(out_valid), 0);
         have_first = 1;
         first_bit  = expr;
      end
      if (run_len > 0 && expr == last_raw) begin
         if (run_len < LIMIT) run_len++;
      end else begin
         run_len = 1;
      end
      last_raw = expr;
      chk("R9 stuck_flag", int'(stuck_flag), int'(run_len >= LIMIT));
      @(negedge clk);
      chk("R8 out_valid one cycle", int'(out_valid), 0);
      k = j + 3;
      while (pulse_out == 1'b0) begin
         @(negedge clk);
         k++;
      end
      if (chklen) chk("R2 low length", k - j, L);
   endtask

   initial begin
      rst  = 1'b1;
      en_n = 1'b1;
      do_reset();
      // Window 0 after reset: enable inactive, count 0
      run_win(99, 99, 0, 0, "R1 R6");
      // Enable onset at every offset of the high phase
      for (int m = 0; m < H; m++) run_win(m, 99, 0, 1, "R3 R5 R6");
      // Enable already low when the window opens
      run_win(99, 99, 1, 1, "R3");
      run_win(-1, 99, 1, 1, "R3 R5");
      run_win(-1, 7, 0, 1, "R4");
      // Enable bursts inside the high phase
      run_win(2, 9, 0, 1, "R4");
      run_win(0, 5, 0, 1, "R4");
      run_win(3, 4, 0, 1, "R4");
      run_win(5, 14, 0, 1, "R4");
      run_win(1, 13, 0, 1, "R4");
      run_win(6, 7, 0, 1, "R4");
      run_win(4, 12, 0, 1, "R4");
      run_win(0, 1, 0, 1, "R4");
      run_win(12, 13, 0, 1, "R4");
      run_win(10, 11, 0, 1, "R4");
      // Leave a lone 1 pending, then reset between pair members (R10)
      if (have_first) run_win(99, 99, 0, 1, "R7");
      run_win(1, 99, 0, 1, "R10");
      chk("R10 pending member before reset", int'(have_first && first_bit), 1);
      do_reset();
      run_win(99, 99, 0, 0, "R10");
      // Long run of equal raw bits for the stuck monitor
      for (int w = 0; w < LIMIT - 2; w++) run_win(99, 99, 0, 1, "R9");
      chk("R9 flag low at 63 equal bits", int'(stuck_flag), 0);
      run_win(99, 99, 0, 1, "R9");
      chk("R9 flag high at 64 equal bits", int'(stuck_flag), 1);
      run_win(1, 99, 0, 1, "R9");
      chk("R9 flag clears on change", int'(stuck_flag), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule